// File: doc/BRIEF.md
# Packed Integer-to-Float Conversion Unit

This unit turns a 256-bit vector of packed 32-bit two's-complement integers into packed IEEE-754 single-precision values. Each lane is converted on its own and lands in the same lane position of the result. Any lane that cannot be represented exactly is rounded to nearest, with ties going to even.

A 2-bit mode input selects how many lanes are converted and what happens to the upper 128 bits of the destination:

- **Legacy 128-bit form:** the low four lanes are converted and the upper half keeps the previous destination value, which arrives on its own input.
- **Extended 128-bit form:** the low four lanes are converted and the upper half is cleared.
- **Extended 256-bit form:** all eight lanes are converted.

The two extended forms also check a 4-bit reserved field. If that field does not hold all ones, the unit raises an invalid-opcode fault and passes the old destination through unchanged.

The result, an inexact flag and the fault flag are registered together. They appear one cycle after the input strobe, qualified by an output strobe.

Top module: `pkd_i2f_unit`

## Requirements
- R1: Each 32-bit source lane is read as a signed two's-complement integer and converted to one single-precision value in the same lane position, with 1 giving 0x3F800000, -1 giving 0xBF800000, 100 giving 0x42C80000 and -100 giving 0xC2C80000.
- R2: Values that need rounding are rounded to nearest, with ties to even:
  - 0x01000001 gives 0x4B800000.
  - 0x01000003 gives 0x4B800002.
  - 0x01000005 gives 0x4B800002.
  - 0x02000003 gives 0x4C000001.
  - 0x7FFFFFFF gives 0x4F000000.
- R3: A zero lane gives 0x00000000, and 0x80000000 (-2^31) gives 0xCF000000 exactly.
- R4: With mode 2'b10 and the reserved field at 4'b1111, all eight lanes (bits 31:0 up to 255:224) are converted.
- R5: With mode 2'b00, lanes 0 to 3 are converted, result bits 255:128 equal the previous-destination bits 255:128, and the reserved field is ignored (no fault for any value).
- R6: With mode 2'b01 and the reserved field at 4'b1111, lanes 0 to 3 are converted and result bits 255:128 are zero.
- R7: With mode 2'b01 or 2'b10 and a reserved field other than 4'b1111, the fault output is 1, the result equals the previous-destination input, and the inexact flag is 0.
- R8: Mode 2'b11 is an invalid encoding. It raises the fault output, passes the previous destination to the result and clears the inexact flag.
- R9: The inexact flag is the OR of the per-lane rounding indications over the lanes active in the selected mode only, and it is 0 when every active lane converts exactly.
- R10: The outputs are registered with one cycle of latency. The output strobe is the input strobe delayed by one cycle. After reset the output strobe, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| mode | input | 2 | 00 legacy 128, 01 extended 128, 10 extended 256, 11 invalid |
| rsv_field | input | 4 | Reserved operand field; must be 4'b1111 in the extended modes |
| src | input | 256 | Packed signed 32-bit integers |
| prev_dst | input | 256 | Current destination contents, used for merging |
| out_valid | output | 1 | Output strobe |
| result | output | 256 | Packed single-precision results |
| inexact | output | 1 | Set when any active lane was rounded |
| ud_fault | output | 1 | Invalid-opcode fault |

## Verification
The bench targets several corner cases, each of which a faulty design would get visibly wrong:

- **Tie rounding above 2^24:** exact halfway cases both above and below an even neighbour expose a unit that truncates or always rounds up, because one of 0x01000003 and 0x01000005 would then land on the odd mantissa.
- **The -2^31 lane:** this catches a magnitude path that overflows on negation.
- **Upper-half handling in the 128-bit forms:** placing inexact-producing values only in the upper lanes shows whether a legacy-mode result leaks converted data, or a flag, from lanes it should have kept.
- **Fault cases:** with both a bad reserved field and mode 2'b11, a design that still writes converted data or raises the inexact flag differs at the result port.
- **Legacy mode with a zero reserved field:** a design that faults here is also reported.

// File: rtl/pkd_i2f_unit.sv
module pkd_i2f_unit #(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            mode,
  input  logic [3:0]            rsv_field,
  input  logic [LANES*32-1:0]   src,
  input  logic [LANES*32-1:0]   prev_dst,
  output logic                  out_valid,
  output logic [LANES*32-1:0]   result,
  output logic                  inexact,
  output logic                  ud_fault
);
  localparam int HALF = LANES / 2;
  localparam int W    = LANES * 32;

  function automatic logic [32:0] cvt_lane(input logic [31:0] v);
    logic [31:0] mag, nrm;
    logic [4:0]  msb;
    logic [30:0] body;
    logic        g, s, up;
    mag = v[31] ? (~v + 32'd1) : v;
    msb = '0;
    for (int b = 0; b < 32; b++)
      if (mag[b]) msb = b[4:0];
    nrm  = mag << (5'd31 - msb);
    g    = nrm[7];
    s    = |nrm[6:0];
    up   = g & (s | nrm[8]);
    body = {8'd127 + {3'd0, msb}, nrm[30:8]} + {30'd0, up};
    if (mag == 32'd0) return 33'd0;
    return {g | s, v[31], body};
  endfunction

  logic             fault;
  logic [LANES-1:0] active, lane_inx;
  logic [W-1:0]     nxt;

  assign fault = (mode == 2'b11) || ((mode != 2'b00) && (rsv_field != 4'hF));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [32:0] c;
    assign c           = cvt_lane(src[i*32 +: 32]);
    assign active[i]   = (i < HALF) || (mode == 2'b10);
    assign lane_inx[i] = c[32] & active[i];
    assign nxt[i*32 +: 32] = fault       ? prev_dst[i*32 +: 32] :
                             active[i]   ? c[31:0] :
                             (mode == 2'b00) ? prev_dst[i*32 +: 32] : 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      inexact   <= 1'b0;
      ud_fault  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt;
        inexact  <= !fault && (|lane_inx);
        ud_fault <= fault;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
  AST_LEGACY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=> (!ud_fault && result[W-1:W/2] == $past(prev_dst[W-1:W/2]))); // R5
  AST_EXT128_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01 && rsv_field == 4'hF) |=> (result[W-1:W/2] == '0)); // R6
  AST_RSV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'b00 && rsv_field != 4'hF) |=> (ud_fault && !inexact && result == $past(prev_dst))); // R7
  AST_MODE3_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> ud_fault); // R8
  AST_FAULT_NO_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ud_fault) |-> !inexact); // R9
endmodule

// File: tb/pkd_i2f_unit_test.sv
module pkd_i2f_unit_test;
  logic         clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0]   mode = 0;
  logic [3:0]   rsv_field = 0;
  logic [255:0] src = '0, prev_dst = '0;
  logic         out_valid, inexact, ud_fault;
  logic [255:0] result;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pkd_i2f_unit uut (.clk, .rst_n, .in_valid, .mode, .rsv_field, .src, .prev_dst,
                    .out_valid, .result, .inexact, .ud_fault);

  // {input, expected float, expected inexact}
  localparam logic [64:0] TAB [12] = '{
    {32'h00000000, 32'h00000000, 1'b0},
    {32'h00000001, 32'h3F800000, 1'b0},
    {32'hFFFFFFFF, 32'hBF800000, 1'b0},
    {32'h80000000, 32'hCF000000, 1'b0},
    {32'h7FFFFFFF, 32'h4F000000, 1'b1},
    {32'h01000001, 32'h4B800000, 1'b1},
    {32'h01000003, 32'h4B800002, 1'b1},
    {32'h01000000, 32'h4B800000, 1'b0},
    {32'h00000064, 32'h42C80000, 1'b0},
    {32'hFFFFFF9C, 32'hC2C80000, 1'b0},
    {32'h01000005, 32'h4B800002, 1'b1},
    {32'h02000003, 32'h4C000001, 1'b1}
  };

  task automatic chk(string tag, logic [255:0] got, logic [255:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [1:0] m, logic [3:0] r, logic [255:0] s, logic [255:0] p);
    @(negedge clk);
    in_valid = 1; mode = m; rsv_field = r; src = s; prev_dst = p;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] s, e, p;
    logic x;
    p = {8{32'hA5A5_5A5A}};
    repeat (2) @(posedge clk); #1;
    chk("R10 reset valid", {255'd0, out_valid}, 0);
    chk("R10 reset result", result, 0);
    chk("R10 reset flags", {254'd0, inexact, ud_fault}, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 12; i++) begin
      x = 0;
      for (int k = 0; k < 8; k++) begin
        s[k*32 +: 32] = TAB[(i+k)%12][64:33];
        e[k*32 +: 32] = TAB[(i+k)%12][32:1];
        x |= TAB[(i+k)%12][0];
      end
      issue(2'b10, 4'hF, s, p);
      chk("R1 R2 R3 R4 lanes", result, e);
      chk("R9 inexact", {255'd0, inexact}, {255'd0, x});
      chk("R10 valid", {255'd0, out_valid}, 1);
    end

    issue(2'b10, 4'hF, {8{32'd100}}, p);
    chk("R9 exact all lanes", {255'd0, inexact}, 0);

    s = {{4{32'h01000003}}, 32'h80000000, 32'h0, 32'hFFFFFF9C, 32'h1};
    issue(2'b00, 4'h0, s, p);
    chk("R5 legacy merge", result, {p[255:128], 32'hCF000000, 32'h0, 32'hC2C80000, 32'h3F800000});
    chk("R5 rsv ignored", {255'd0, ud_fault}, 0);
    chk("R9 upper lanes not counted", {255'd0, inexact}, 0);

    issue(2'b01, 4'hF, s, p);
    chk("R6 ext128 clear", result, {128'd0, 32'hCF000000, 32'h0, 32'hC2C80000, 32'h3F800000});
    chk("R9 ext128 inexact", {255'd0, inexact}, 0);

    issue(2'b01, 4'hF, {{4{32'h0}}, 32'h7FFFFFFF, 96'd0}, p);
    chk("R2 R9 lane3 rounding", {255'd0, inexact}, 1);

    issue(2'b01, 4'hE, {8{32'h7FFFFFFF}}, p);
    chk("R7 fault ext128", {255'd0, ud_fault}, 1);
    chk("R7 dest kept", result, p);
    chk("R7 no inexact", {255'd0, inexact}, 0);

    issue(2'b10, 4'h7, {8{32'h01000001}}, p);
    chk("R7 fault ext256", {254'd0, ud_fault, inexact}, 2);
    chk("R7 dest kept 256", result, p);

    issue(2'b11, 4'hF, {8{32'h01000001}}, p);
    chk("R8 mode3 fault", {254'd0, ud_fault, inexact}, 2);
    chk("R8 dest kept", result, p);

    @(negedge clk); @(posedge clk); #1;
    chk("R10 idle valid low", {255'd0, out_valid}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule